// File: doc/BRIEF.md
# Serial LCD Command Framer

This block takes write requests for a character/graphics LCD controller and sends each one over a three-wire synchronous serial link: an active-high chip select, a serial clock and one data line. A request is an instruction, a graphics address write, or a burst of graphics data bytes. The block forms the frame and sends its bits out. A frame is one sync byte, then every payload byte split into two nibble-carrying bytes.

Each request is accepted on a valid/ready handshake. `req_ready` is high only while the block is idle. The upstream side must hold `req_valid` and the request fields until the cycle in which `req_valid && req_ready` is true. After that cycle the block keeps its own copy of the request, so the upstream side may change or withdraw its inputs at once. The upstream side waits for `req_ready` to return before it presents the next request. A one-cycle `frame_done` pulse marks the end of each frame. Any waiting between commands is left to the logic upstream.

Top module: `lcd_serial_framer`

## Requirements
- R1: Byte 0 of every frame is the sync byte: bits 7..3 are ones, bit 2 (direction) is 0, bit 1 (register select) is 0 for instruction, address and reserved kinds and 1 for graphics data, and bit 0 is 0. This gives 0xF8 or 0xFA.
- R2: Each payload byte b is sent as two wire bytes: first {b[7:4],4'h0}, then {b[3:0],4'h0}.
- R3: Kind 2'b00 (instruction) sends a 3-byte frame: sync, then the nibble pair of `req_instr`.
- R4: Kind 2'b01 (address write) sends a 5-byte frame: sync, then the nibble pair of `req_instr` (vertical address), then the nibble pair of `req_aux` (horizontal address).
- R5: Kind 2'b10 (graphics data) sends sync plus DATA_BYTES payload bytes, which is 33 wire bytes at the default. Payload byte k is `req_data[8k+7:8k]` and byte 0 goes first.
- R6: Bits go out most significant first. `lcd_sdo` changes only while `lcd_sclk` is low and holds steady through every high phase.
- R7: `lcd_sclk` is low when idle. During a frame each high phase and each low phase lasts SCLK_DIV/2 system cycles, so rising edges are SCLK_DIV cycles apart.
- R8: `lcd_cs` goes high in the cycle after acceptance, SCLK_DIV/2 cycles before the first rising clock edge. It falls SCLK_DIV/2 cycles after the last falling clock edge. `lcd_sclk` never goes high while `lcd_cs` is low.
- R9: `req_ready` is low from the cycle after acceptance until the frame ends. Request inputs that change, or a `req_valid` raised, while the block is busy have no effect on the frame in progress and start no extra frame.
- R10: `frame_done` is a single-cycle pulse in the cycle in which `lcd_cs` falls, and `req_ready` is high in that same cycle.
- R11: Kind 2'b11 is reserved and is framed exactly like an instruction (3 bytes, register select 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_kind | input | 2 | 00 instruction, 01 address write, 10 graphics data, 11 reserved |
| req_instr | input | 8 | Instruction byte, or vertical address for an address write |
| req_aux | input | 8 | Horizontal address for an address write |
| req_data | input | 8*DATA_BYTES | Graphics payload, byte 0 in the low bits |
| lcd_cs | output | 1 | Serial chip select, active high |
| lcd_sclk | output | 1 | Serial clock, idle low |
| lcd_sdo | output | 1 | Serial data, MSB first |
| frame_done | output | 1 | One-cycle pulse at frame end |

## Verification
Directed frames cover the cases below, each decoded from the wire at the rising clock edges.
- Instructions with distinct high and low nibbles show that the nibble halves are not swapped.
- An address write with different vertical and horizontal values checks their order.
- A graphics burst with a ramp pattern confirms the byte order and the set register-select bit.
- A burst of alternating all-ones and all-zeros bytes shows that zero padding and long runs of one level keep their bit alignment.
- The reserved kind is sent and compared against instruction framing.
- A busy-time test changes the payload and raises `req_valid` during a burst, which separates a correctly latched request from one that leaks live inputs or accepts a second request.

// File: rtl/lcdf_pkg.sv
package lcdf_pkg;

  typedef enum logic [1:0] {
    KIND_INSTR = 2'b00,
    KIND_ADDR  = 2'b01,
    KIND_DATA  = 2'b10,
    KIND_RSVD  = 2'b11
  } req_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HIGH,
    ST_LOW,
    ST_TAIL
  } link_state_e;

  localparam logic [7:0] SYNC_BASE = 8'hF8;
  localparam logic [7:0] DIR_BIT   = 8'h04;
  localparam logic [7:0] RSEL_BIT  = 8'h02;

  // one half of a payload byte, moved into the upper nibble
  function automatic logic [7:0] nibble_byte(input logic [7:0] b, input logic low_half);
    return low_half ? {b[3:0], 4'h0} : {b[7:4], 4'h0};
  endfunction

endpackage

// File: rtl/lcdf_byte_sel.sv
module lcdf_byte_sel
  import lcdf_pkg::*;
#(
  parameter int DATA_BYTES = 16,
  localparam int IDX_W = $clog2(2 * DATA_BYTES + 1),
  localparam int KW    = $clog2(DATA_BYTES)
) (
  input  req_kind_e                 kind,
  input  logic [7:0]                instr,
  input  logic [7:0]                aux,
  input  logic [8*DATA_BYTES-1:0]   data,
  input  logic [IDX_W-1:0]          idx,
  output logic [7:0]                wire_byte,
  output logic [IDX_W-1:0]          last_idx
);

  logic [7:0]       dbytes [DATA_BYTES];
  logic [IDX_W-1:0] pos;
  logic [KW-1:0]    k_sel;
  logic [7:0]       payload;

  for (genvar g = 0; g < DATA_BYTES; g++) begin : g_unpack
    assign dbytes[g] = data[8*g +: 8];
  end

  assign pos   = idx - IDX_W'(1);
  assign k_sel = KW'(pos >> 1);

  always_comb begin
    unique case (kind)
      KIND_ADDR: last_idx = IDX_W'(4);
      KIND_DATA: last_idx = IDX_W'(2 * DATA_BYTES);
      default:   last_idx = IDX_W'(2);
    endcase
  end

  always_comb begin
    unique case (kind)
      KIND_DATA: payload = dbytes[k_sel];
      KIND_ADDR: payload = (k_sel == '0) ? instr : aux;
      default:   payload = instr;
    endcase
  end

  always_comb begin
    if (idx == '0) begin
      wire_byte = SYNC_BASE | ((kind == KIND_DATA) ? RSEL_BIT : 8'h00);
    end else begin
      wire_byte = nibble_byte(payload, pos[0]);
    end
  end

endmodule

// File: rtl/lcdf_sclk_gen.sv
module lcdf_sclk_gen #(
  parameter int SCLK_DIV = 4,
  localparam int HALF = SCLK_DIV / 2,
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic phase_end
);

  logic [CW-1:0] cnt;

  assign phase_end = run && (cnt == CW'(HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || phase_end) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

endmodule

// File: rtl/lcdf_ctrl.sv
module lcdf_ctrl
  import lcdf_pkg::*;
#(
  parameter int DATA_BYTES = 16,
  localparam int IDX_W = $clog2(2 * DATA_BYTES + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [1:0]                req_kind,
  input  logic [7:0]                req_instr,
  input  logic [7:0]                req_aux,
  input  logic [8*DATA_BYTES-1:0]   req_data,
  input  logic                      phase_end,
  output logic                      run,
  output req_kind_e                 lat_kind,
  output logic [7:0]                lat_instr,
  output logic [7:0]                lat_aux,
  output logic [8*DATA_BYTES-1:0]   lat_data,
  output logic [IDX_W-1:0]          byte_idx,
  input  logic [IDX_W-1:0]          last_idx,
  input  logic [7:0]                cur_byte,
  output logic                      lcd_cs,
  output logic                      lcd_sclk,
  output logic                      lcd_sdo,
  output logic                      frame_done
);

  link_state_e state;
  logic [2:0]  bit_cnt;
  logic        last_bit;

  assign last_bit  = (bit_cnt == 3'd7) && (byte_idx == last_idx);
  assign req_ready = (state == ST_IDLE);
  assign lcd_cs    = (state != ST_IDLE);
  assign lcd_sclk  = (state == ST_HIGH);
  assign lcd_sdo   = lcd_cs ? cur_byte[3'd7 - bit_cnt] : 1'b0;
  assign run       = lcd_cs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      bit_cnt    <= '0;
      byte_idx   <= '0;
      frame_done <= 1'b0;
      lat_kind   <= KIND_INSTR;
      lat_instr  <= '0;
      lat_aux    <= '0;
      lat_data   <= '0;
    end else begin
      frame_done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            lat_kind  <= req_kind_e'(req_kind);
            lat_instr <= req_instr;
            lat_aux   <= req_aux;
            lat_data  <= req_data;
            byte_idx  <= '0;
            bit_cnt   <= '0;
            state     <= ST_LEAD;
          end
        end
        ST_LEAD: if (phase_end) state <= ST_HIGH;
        ST_HIGH: begin
          if (phase_end) begin
            if (last_bit) begin
              state <= ST_TAIL;
            end else begin
              state <= ST_LOW;
              if (bit_cnt == 3'd7) begin
                bit_cnt  <= '0;
                byte_idx <= byte_idx + IDX_W'(1);
              end else begin
                bit_cnt <= bit_cnt + 3'd1;
              end
            end
          end
        end
        ST_LOW: if (phase_end) state <= ST_HIGH;
        ST_TAIL: begin
          if (phase_end) begin
            state      <= ST_IDLE;
            frame_done <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9
  accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  // R10
  done_at_cs_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lcd_cs) |-> frame_done);

  // R6
  sdo_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_sclk && $past(lcd_sclk)) |-> $stable(lcd_sdo));

  // R8
  cs_before_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcd_cs) |-> !lcd_sclk);

  // R1
  sync_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_cs && byte_idx == '0) |->
      (cur_byte[7:3] == 5'h1F && cur_byte[2] == 1'b0 && cur_byte[0] == 1'b0));

  // R2
  nibble_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_cs && byte_idx != '0) |-> (cur_byte[3:0] == 4'h0));

endmodule

// File: rtl/lcd_serial_framer.sv
module lcd_serial_framer
  import lcdf_pkg::*;
#(
  parameter int DATA_BYTES = 16,
  parameter int SCLK_DIV   = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [1:0]                req_kind,
  input  logic [7:0]                req_instr,
  input  logic [7:0]                req_aux,
  input  logic [8*DATA_BYTES-1:0]   req_data,
  output logic                      lcd_cs,
  output logic                      lcd_sclk,
  output logic                      lcd_sdo,
  output logic                      frame_done
);

  localparam int IDX_W = $clog2(2 * DATA_BYTES + 1);

  logic                    phase_end;
  logic                    run;
  req_kind_e               lat_kind;
  logic [7:0]              lat_instr;
  logic [7:0]              lat_aux;
  logic [8*DATA_BYTES-1:0] lat_data;
  logic [IDX_W-1:0]        byte_idx;
  logic [IDX_W-1:0]        last_idx;
  logic [7:0]              cur_byte;

  lcdf_sclk_gen #(.SCLK_DIV(SCLK_DIV)) u_clkgen (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .phase_end (phase_end)
  );

  lcdf_byte_sel #(.DATA_BYTES(DATA_BYTES)) u_bytesel (
    .kind      (lat_kind),
    .instr     (lat_instr),
    .aux       (lat_aux),
    .data      (lat_data),
    .idx       (byte_idx),
    .wire_byte (cur_byte),
    .last_idx  (last_idx)
  );

  lcdf_ctrl #(.DATA_BYTES(DATA_BYTES)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_kind   (req_kind),
    .req_instr  (req_instr),
    .req_aux    (req_aux),
    .req_data   (req_data),
    .phase_end  (phase_end),
    .run        (run),
    .lat_kind   (lat_kind),
    .lat_instr  (lat_instr),
    .lat_aux    (lat_aux),
    .lat_data   (lat_data),
    .byte_idx   (byte_idx),
    .last_idx   (last_idx),
    .cur_byte   (cur_byte),
    .lcd_cs     (lcd_cs),
    .lcd_sclk   (lcd_sclk),
    .lcd_sdo    (lcd_sdo),
    .frame_done (frame_done)
  );

endmodule

// File: tb/sim_lcd_serial_framer.sv
`timescale 1ns/1ps
module sim_lcd_serial_framer;

  localparam int NB   = 16;
  localparam int DIV  = 4;
  localparam int HALF = DIV / 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic [1:0]      req_kind = 2'b00;
  logic [7:0]      req_instr = 8'h00;
  logic [7:0]      req_aux = 8'h00;
  logic [8*NB-1:0] req_data = '0;
  logic            lcd_cs, lcd_sclk, lcd_sdo, frame_done;

  always #2.5 clk = ~clk;

  lcd_serial_framer #(.DATA_BYTES(NB), .SCLK_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_instr(req_instr), .req_aux(req_aux),
    .req_data(req_data), .lcd_cs(lcd_cs), .lcd_sclk(lcd_sclk),
    .lcd_sdo(lcd_sdo), .frame_done(frame_done)
  );

  int checks = 0;
  int failures = 0;

  // wire monitor, sampled at the falling system clock edge
  int         cyc = 0;
  logic [7:0] cap [0:63];
  int         nbits, cs_rise, cs_fall, first_rise, last_rise, min_per, max_per;
  int         sdo_glitch = 0, ready_bad = 0, sclk_no_cs = 0, done_cnt = 0, done_bad = 0;
  logic       p_cs = 1'b0, p_sclk = 1'b0, p_sdo = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (lcd_cs && !p_cs) begin
      nbits = 0; cs_rise = cyc; first_rise = -1; min_per = 99999; max_per = 0;
    end
    if (lcd_sclk && !p_sclk) begin
      cap[nbits >> 3] = {cap[nbits >> 3][6:0], lcd_sdo};
      nbits++;
      if (first_rise < 0) first_rise = cyc;
      else begin
        if (cyc - last_rise < min_per) min_per = cyc - last_rise;
        if (cyc - last_rise > max_per) max_per = cyc - last_rise;
      end
      last_rise = cyc;
    end
    if (lcd_sclk && p_sclk && lcd_sdo != p_sdo) sdo_glitch++;
    if (lcd_cs && req_ready) ready_bad++;
    if (!lcd_cs && lcd_sclk) sclk_no_cs++;
    if (!lcd_cs && p_cs) cs_fall = cyc;
    if (frame_done) begin
      done_cnt++;
      if (lcd_cs || !req_ready) done_bad++;
    end
    p_cs = lcd_cs; p_sclk = lcd_sclk; p_sdo = lcd_sdo;
  end

  task automatic check(input string rq, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", rq, what, act, exp);
    end
  endtask

  function automatic int exp_len(input int kind);
    return (kind == 2) ? 1 + 2 * NB : (kind == 1) ? 5 : 3;
  endfunction

  function automatic int exp_byte(input int kind, input logic [7:0] ins, input logic [7:0] ax,
                                  input logic [8*NB-1:0] d, input int idx);
    logic [7:0] b;
    int p, k;
    if (idx == 0) return (kind == 2) ? 8'hFA : 8'hF8;
    p = idx - 1; k = p / 2;
    if (kind == 2) b = d[k*8 +: 8];
    else if (kind == 1 && k == 1) b = ax;
    else b = ins;
    return (p % 2 == 1) ? {b[3:0], 4'h0} : {b[7:4], 4'h0};
  endfunction

  task automatic wait_done(input int d0);
    int n = 0;
    while (done_cnt == d0 && n < 5000) begin
      @(negedge clk); n++;
    end
    if (done_cnt == d0) begin
      checks++; failures++;
      $display("FAIL R10 watchdog: actual=no frame end expected=frame end");
    end
    @(negedge clk);
  endtask

  task automatic send(input int kind, input logic [7:0] ins, input logic [7:0] ax,
                      input logic [8*NB-1:0] d);
    int d0 = done_cnt;
    @(negedge clk);
    req_kind = 2'(kind); req_instr = ins; req_aux = ax; req_data = d; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done(d0);
  endtask

  task automatic verify(input int kind, input logic [7:0] ins, input logic [7:0] ax,
                        input logic [8*NB-1:0] d, input string rq);
    int len = exp_len(kind);
    check(rq, "frame bit count", nbits, 8 * len);
    check("R1", "sync byte", cap[0], exp_byte(kind, ins, ax, d, 0));
    for (int i = 1; i < len; i++)
      check(rq, $sformatf("R2 wire byte %0d", i), cap[i], exp_byte(kind, ins, ax, d, i));
    check("R8", "cs lead to first rise", first_rise - cs_rise, HALF);
    check("R8", "last rise to cs fall", cs_fall - last_rise, DIV);
    check("R7", "min sclk period", min_per, DIV);
    check("R7", "max sclk period", max_per, DIV);
    check("R6", "sdo moved while sclk high", sdo_glitch, 0);
    check("R9", "ready high while busy", ready_bad, 0);
    check("R8", "sclk high without cs", sclk_no_cs, 0);
    check("R10", "done not aligned with cs fall", done_bad, 0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check("R7", "sclk in reset", lcd_sclk, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R8", "cs idle", lcd_cs, 0);
    check("R7", "sclk idle", lcd_sclk, 0);
    check("R6", "sdo idle", lcd_sdo, 0);
    check("R9", "ready idle", req_ready, 1);
    check("R10", "done idle", frame_done, 0);
  endtask

  task automatic t_instr;
    send(0, 8'h30, 8'h00, '0);  verify(0, 8'h30, 8'h00, '0, "R3");
    send(0, 8'h0C, 8'h00, '0);  verify(0, 8'h0C, 8'h00, '0, "R3");
    send(0, 8'hA5, 8'h00, '0);  verify(0, 8'hA5, 8'h00, '0, "R3");
  endtask

  task automatic t_addr;
    send(1, 8'h85, 8'h80, '0);  verify(1, 8'h85, 8'h80, '0, "R4");
    send(1, 8'h9F, 8'h03, '0);  verify(1, 8'h9F, 8'h03, '0, "R4");
  endtask

  task automatic t_data_ramp;
    logic [8*NB-1:0] d;
    for (int i = 0; i < NB; i++) d[i*8 +: 8] = 8'(8'h11 * i + 8'h07);
    send(2, 8'h00, 8'h00, d);  verify(2, 8'h00, 8'h00, d, "R5");
  endtask

  task automatic t_data_edges;
    logic [8*NB-1:0] d;
    for (int i = 0; i < NB; i++) d[i*8 +: 8] = (i % 2 == 0) ? 8'hFF : 8'h00;
    send(2, 8'h00, 8'h00, d);  verify(2, 8'h00, 8'h00, d, "R5");
  endtask

  task automatic t_reserved;
    send(3, 8'h3C, 8'hEE, '0);  verify(0, 8'h3C, 8'hEE, '0, "R11");
  endtask

  task automatic t_busy_ignore;
    logic [8*NB-1:0] d;
    int d0 = done_cnt;
    for (int i = 0; i < NB; i++) d[i*8 +: 8] = 8'(8'hC3 ^ (i * 8'h1D));
    @(negedge clk);
    req_kind = 2'b10; req_data = d; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (40) @(negedge clk);
    req_kind = 2'b00; req_data = ~d; req_instr = 8'h77; req_valid = 1'b1;
    repeat (10) @(negedge clk);
    req_valid = 1'b0;
    wait_done(d0);
    repeat (20) @(negedge clk);
    check("R9", "frames started", done_cnt - d0, 1);
    check("R9", "cs after ignored request", lcd_cs, 0);
    verify(2, 8'h00, 8'h00, d, "R9");
  endtask

  initial begin
    t_reset();
    t_instr();
    t_addr();
    t_data_ramp();
    t_data_edges();
    t_reserved();
    t_busy_ignore();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule